// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a register-mapped watchdog. It counts input-clock ticks while it is switched on and compares the count against two thresholds set by software. An early-warning threshold raises an interrupt level so that software has a chance to act. A final threshold issues a one-cycle reset request to the system. Software keeps the watchdog quiet by writing to a restart register, which sends the tick count back to zero. A sticky status flag records that a reset request came from the watchdog, so software can see the cause after the system reset.

The block has two reset inputs. The power-on reset clears everything. The system reset, which the reset request normally drives through logic outside this block, clears everything except the status flag. Both resets are synchronous and active high. Accesses use a simple 32-bit register bus. A request is taken in one cycle, and the response ready, with the read data, comes exactly one cycle later.

Top module: `wdog_two_stage`

## Requirements
- R1: A request is taken at the clock edge where `req_valid` is high. Writes take effect at that edge. `rsp_ready` is high for exactly the following cycle, and on a read `rsp_rdata` carries the value in that same cycle. The offsets are restart 0x04, control 0x08, status 0x0C, warning threshold 0x10 and final threshold 0x14. Unmapped offsets read as 0.
- R2: Control bit 0 runs the tick counter and control bit 1 enables the interrupt. The control register reads back as written in bits [1:0]. `bark_irq` is the warning level ANDed with control bit 1.
- R3: The tick counter increases by one on each edge where control bit 0 was already set. It holds its value while bit 0 is clear, and it resumes from that value when bit 0 is set again.
- R4: Writing the restart register with bit 0 = 1 clears the counter, the warning level and the final-stage latch at that edge. A write with bit 0 = 0 has no effect.
- R5: The warning level rises one edge after the counter equals the warning threshold while running. It stays high until a restart, or until a control write with bit 0 = 0.
- R6: `bite_req` goes high for exactly one cycle, one edge after the counter equals the final threshold while running. It fires at most once until the next restart, stop or reset.
- R7: When both thresholds are equal, the warning level and `bite_req` rise in the same cycle.
- R8: A threshold at or above 2^CNT_W (0x10000000 by default) never matches. This holds even when its low bits equal the count.
- R9: Status bit 0 becomes 1 in the cycle `bite_req` is high. `sys_rst` leaves it unchanged. It returns to 0 only on `por_rst` or on a status write with bit 0 = 1.
- R10: After either reset, control reads 0, both thresholds read 0xFFFFFFFF, and `bark_irq`, `bite_req` and `rsp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick and bus clock |
| por_rst | input | 1 | Power-on reset, clears all state including status |
| sys_rst | input | 1 | System reset, clears all state except status |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| bark_irq | output | 1 | Early-warning interrupt level |
| bite_req | output | 1 | One-cycle system reset request |

## Verification
The assertions make these assumptions about the inputs:
- A single request strobe covers one access only.
- The power-on reset is applied at least once before any check counts.
- The thresholds are not changed while the counter is crossing them.

The stimulus follows these rules. It issues requests one at a time, each held for a single cycle. It starts with both resets high. It programs the thresholds only while the counter is stopped or far below them. It pulses `sys_rst` after each reset request, the way an outside reset controller would.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] OFS_PET  = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_WARN = 8'h10;
  localparam logic [7:0] OFS_KILL = 8'h14;

  localparam int N_STAGE  = 2;
  localparam int STG_BARK = 0;
  localparam int STG_BITE = 1;

  typedef struct packed {
    logic irq_en;
    logic cnt_en;
  } ctl_t;

endpackage

// File: rtl/wdog_bus_regs.sv
module wdog_bus_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  input  logic                            status_flag,
  output logic                            rsp_ready,
  output logic [DATA_W-1:0]               rsp_rdata,
  output ctl_t                            ctl,
  output logic [N_STAGE-1:0][DATA_W-1:0]  thr,
  output logic                            restart_pulse,
  output logic                            stop_pulse,
  output logic                            status_clr
);

  logic wr_en;
  logic hit_pet, hit_ctl, hit_stat, hit_warn, hit_kill;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en    = req_valid & req_write;
  assign hit_pet  = (req_addr == ADDR_W'(OFS_PET));
  assign hit_ctl  = (req_addr == ADDR_W'(OFS_CTL));
  assign hit_stat = (req_addr == ADDR_W'(OFS_STAT));
  assign hit_warn = (req_addr == ADDR_W'(OFS_WARN));
  assign hit_kill = (req_addr == ADDR_W'(OFS_KILL));

  assign restart_pulse = wr_en & hit_pet  &  req_wdata[0];
  assign stop_pulse    = wr_en & hit_ctl  & ~req_wdata[0];
  assign status_clr    = wr_en & hit_stat &  req_wdata[0];

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)  rd_mux = DATA_W'({ctl.irq_en, ctl.cnt_en});
    if (hit_stat) rd_mux = DATA_W'(status_flag);
    if (hit_warn) rd_mux = thr[STG_BARK];
    if (hit_kill) rd_mux = thr[STG_BITE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      thr       <= '1;
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      if (wr_en) begin
        if (hit_ctl)  ctl <= '{irq_en: req_wdata[1], cnt_en: req_wdata[0]};
        if (hit_warn) thr[STG_BARK] <= req_wdata;
        if (hit_kill) thr[STG_BITE] <= req_wdata;
      end
    end
  end

  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> $past(req_valid)); // R1

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rsp_ready) |-> 1'b1 ##1 rsp_ready); // R1

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (run && count != CNT_MAX)
      count <= count + 1'b1;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(count)); // R3

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0)); // R4

endmodule

// File: rtl/wdog_threshold_hit.sv
module wdog_threshold_hit #(
  parameter int CNT_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] thr,
  input  logic [CNT_W-1:0]  count,
  output logic              hit
);

  localparam int HI_W = DATA_W - CNT_W;

  logic in_range;

  assign in_range = (thr[DATA_W-1:CNT_W] == HI_W'(0));
  assign hit      = in_range && (thr[CNT_W-1:0] == count);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 28
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bark_irq,
  output logic              bite_req
);

  logic rst_any;
  ctl_t ctl;
  logic [N_STAGE-1:0][DATA_W-1:0] thr;
  logic [N_STAGE-1:0] hit;
  logic restart_pulse, stop_pulse, status_clr;
  logic [CNT_W-1:0] count;
  logic bark_lvl, bitten, bite_q, status_q;
  logic bark_set, bite_fire;

  assign rst_any = por_rst | sys_rst;

  wdog_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst_any),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .status_flag(status_q),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ctl(ctl), .thr(thr),
    .restart_pulse(restart_pulse), .stop_pulse(stop_pulse),
    .status_clr(status_clr)
  );

  wdog_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst_any), .clear(restart_pulse),
    .run(ctl.cnt_en), .count(count)
  );

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    wdog_threshold_hit #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_hit (
      .thr(thr[s]), .count(count), .hit(hit[s])
    );
  end

  assign bark_set  = ctl.cnt_en && hit[STG_BARK] && !restart_pulse && !stop_pulse;
  assign bite_fire = ctl.cnt_en && hit[STG_BITE] && !bitten &&
                     !restart_pulse && !stop_pulse;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      bark_lvl <= 1'b0;
      bitten   <= 1'b0;
      bite_q   <= 1'b0;
    end else begin
      bite_q <= bite_fire;
      if (restart_pulse || stop_pulse) begin
        bark_lvl <= 1'b0;
        bitten   <= 1'b0;
      end else begin
        bark_lvl <= bark_lvl | bark_set;
        bitten   <= bitten | bite_fire;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst)
      status_q <= 1'b0;
    else if (bite_fire)
      status_q <= 1'b1;
    else if (status_clr)
      status_q <= 1'b0;
  end

  assign bark_irq = bark_lvl & ctl.irq_en;
  assign bite_req = bite_q;

  AST_BITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst_any)
    bite_req |=> !bite_req); // R6

  AST_STATUS_ON_BITE: assert property (@(posedge clk) disable iff (por_rst)
    bite_req |-> status_q); // R9

  AST_BARK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst_any)
    $rose(bark_lvl) |-> $past(ctl.cnt_en)); // R5

endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        por_rst, sys_rst;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic        bark_irq, bite_req;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_stage u0 (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bark_irq(bark_irq), .bite_req(bite_req)
  );

  // {write, addr, data, expected read}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b0, 8'h08, 32'h0,        32'h0},         // R10 control reset
    {1'b0, 8'h10, 32'h0,        32'hFFFFFFFF},  // R10 warning reset
    {1'b0, 8'h14, 32'h0,        32'hFFFFFFFF},  // R10 final reset
    {1'b0, 8'h0C, 32'h0,        32'h0},         // R9 status after por
    {1'b1, 8'h10, 32'h00000123, 32'h0},
    {1'b0, 8'h10, 32'h0,        32'h00000123},  // R1
    {1'b1, 8'h14, 32'hABCD0000, 32'h0},
    {1'b0, 8'h14, 32'h0,        32'hABCD0000},  // R1
    {1'b1, 8'h08, 32'h00000002, 32'h0},
    {1'b0, 8'h08, 32'h0,        32'h00000002},  // R2
    {1'b1, 8'h08, 32'h0,        32'h0},
    {1'b0, 8'h04, 32'h0,        32'h0},         // R1 restart reads 0
    {1'b0, 8'h20, 32'h0,        32'h0}          // R1 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(posedge clk);
    @(negedge clk);
    d = rsp_rdata;
    check("R1 ready", {31'b0, rsp_ready}, 32'h1);
    req_valid = 1'b0;
  endtask

  task automatic pulse_sys;
    sys_rst = 1'b1;
    tick(2);
    sys_rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic seen;
    por_rst = 1'b1; sys_rst = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    tick(3);
    por_rst = 1'b0; sys_rst = 1'b0;
    check("R10 irq", {31'b0, bark_irq}, 0);
    check("R10 bite", {31'b0, bite_req}, 0);
    check("R10 ready", {31'b0, rsp_ready}, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][72]) begin
        wr(VEC[i][71:64], VEC[i][63:32]);
        check("R1 write ready", {31'b0, rsp_ready}, 32'h1);
      end else begin
        rd(VEC[i][71:64], d);
        check("R1/R2/R10 readback", d, VEC[i][31:0]);
      end
    end

    // main sequence: warning at 5, final at 9
    wr(8'h10, 5); wr(8'h14, 9); wr(8'h04, 1); wr(8'h08, 3);
    tick(5); check("R5 before warn", {31'b0, bark_irq}, 0);
    tick(1); check("R5 warn", {31'b0, bark_irq}, 1);
    tick(3); check("R6 before bite", {31'b0, bite_req}, 0);
    tick(1); check("R6 bite", {31'b0, bite_req}, 1);
    tick(1); check("R6 bite one cycle", {31'b0, bite_req}, 0);
    seen = 1'b0;
    for (int k = 0; k < 5; k++) begin tick(1); seen |= bite_req; end
    check("R6 bite once", {31'b0, seen}, 0);
    check("R5 warn held", {31'b0, bark_irq}, 1);
    rd(8'h0C, d); check("R9 status set", d, 1);
    pulse_sys;
    rd(8'h0C, d); check("R9 survives sys_rst", d, 1);
    rd(8'h08, d); check("R10 control after sys_rst", d, 0);
    check("R10 irq after sys_rst", {31'b0, bark_irq}, 0);

    // interrupt gating
    wr(8'h10, 3); wr(8'h04, 1); wr(8'h08, 1);
    tick(4); check("R2 irq gated", {31'b0, bark_irq}, 0);
    wr(8'h08, 3); check("R2 irq enabled", {31'b0, bark_irq}, 1);
    wr(8'h08, 0); check("R5 stop clears", {31'b0, bark_irq}, 0);
    wr(8'h08, 3); check("R5 stays clear", {31'b0, bark_irq}, 0);

    // hold while stopped
    wr(8'h08, 0); wr(8'h04, 1); wr(8'h10, 20); wr(8'h08, 1);
    tick(10); wr(8'h08, 0); tick(50); wr(8'h08, 3);
    tick(9); check("R3 held count", {31'b0, bark_irq}, 0);
    tick(1); check("R3 resumed count", {31'b0, bark_irq}, 1);

    // restart behaviour
    wr(8'h04, 1); check("R4 restart clears warn", {31'b0, bark_irq}, 0);
    tick(5); wr(8'h04, 0);
    tick(14); check("R4 ignored write", {31'b0, bark_irq}, 0);
    tick(1); check("R4 count not cleared", {31'b0, bark_irq}, 1);

    // equal thresholds
    wr(8'h08, 0); wr(8'h04, 1); wr(8'h10, 4); wr(8'h14, 4); wr(8'h08, 3);
    tick(4); check("R7 before", {30'b0, bark_irq, bite_req}, 0);
    tick(1); check("R7 together", {30'b0, bark_irq, bite_req}, 3);
    pulse_sys;

    // thresholds out of range
    wr(8'h10, 32'h10000000); wr(8'h14, 32'h10000002); wr(8'h04, 1); wr(8'h08, 3);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin tick(1); seen |= bite_req | bark_irq; end
    check("R8 no match", {31'b0, seen}, 0);

    // status clear paths
    rd(8'h0C, d); check("R9 status still set", d, 1);
    wr(8'h0C, 1);
    rd(8'h0C, d); check("R9 write-one clears", d, 0);
    wr(8'h08, 0); wr(8'h04, 1); wr(8'h10, 2); wr(8'h14, 2); wr(8'h08, 1);
    tick(4);
    rd(8'h0C, d); check("R9 set again", d, 1);
    por_rst = 1'b1; tick(2); por_rst = 1'b0;
    rd(8'h0C, d); check("R9 por clears", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule